// File: doc/BRIEF.md
# Remote Core Reset and Boot Controller

This block lets the controlling side of a two-core system put the other core into reset, keep it there for as long as needed, and then let it run again with a chosen boot mode. The controlling side writes a small control word that holds a reset request, a reset hold and a boot-mode field. The block drives a reset line and a boot-mode bus toward the remote core.

The remote core reports back through an acknowledge input. The input is high while the core sits in reset. A second input lets the remote core refuse reset requests. Two sticky pending flags record that the remote core has gone down and that it has come back up. Software clears each flag by writing a one to its bit, and it clears both flags before it starts a new reset.

A typical sequence runs as follows. Software clears the flags and sets the request, with or without hold. It waits for the entered-reset flag. To release the core, it writes one control word that has request and hold both at zero and carries the new boot mode. It then waits for the left-reset flag.

Top module: `remote_reset_ctrl`

## Requirements
- R1: After reset, the reset output is low. The boot-mode output, both pending flags and all control fields are zero.
- R2: The control word layout is: bit 0 is the reset request, bit 1 is the reset hold, and bits 3:2 are the boot mode. A write takes effect on the clock edge where `cfgWrEn` is high.
- R3: When the stored request is 1 and `remoteMask` is low, `remoteRst` goes high on the next clock edge after the request was stored.
- R4: While the reset output is high and hold is 1, the reset output stays high, even after the request is cleared.
- R5: When both request and hold are 0 while the reset output is high, the reset output falls on the next edge.
- R6: The boot-mode output takes the stored boot field on the edge where the reset output falls. At all other times it keeps its value, so changes to the boot field while the core is held have no effect.
- R7: The assert-pending flag (status bit 0) sets on the first edge where `remoteAck` is seen high after being low, but only while the reset output is high.
- R8: The deassert-pending flag (status bit 1) sets on the edge where `remoteAck` is seen low after the remote core acknowledged reset, but only once the reset output has been released.
- R9: Writing 1 to a status bit clears that flag and leaves the other flag unchanged. A set event in the same cycle as a clear wins over the clear.
- R10: While `remoteMask` is high, a stored request does not raise the reset output, and the assert-pending flag never sets. When the mask drops and the request is still stored, reset starts on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 4 | Control word: {boot[1:0], hold, request} |
| statClrEn | input | 1 | Status write-one-to-clear strobe |
| statClrData | input | 2 | Bits to clear: {deassert pending, assert pending} |
| remoteAck | input | 1 | Remote core reports that it is in reset |
| remoteMask | input | 1 | Remote core refuses reset requests |
| remoteRst | output | 1 | Reset line to the remote core |
| bootMode | output | 2 | Boot mode presented to the remote core |
| assertPend | output | 1 | Remote core has entered reset |
| deassertPend | output | 1 | Remote core has left reset |

## Verification
Each fault in the internal state shows at the ports within one or two clock edges:
- A reset state that is wrong shows on `remoteRst` on the edge after the request, hold or mask condition changes.
- A hold that has been lost drops the reset line while the remote core should still be held.
- A boot latch that is wrong shows a mode change on `bootMode` while the core is held, or a stale mode right after release.
- Acknowledge tracking that is wrong appears as a pending flag that sets on an acknowledge edge it should ignore, or that does not set one edge after a valid one.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  // Events the control side hands to the datapath, one cycle wide each.
  typedef struct packed {
    logic rstRise;    // reset line goes high on this edge
    logic rstFall;    // reset line goes low on this edge
    logic enterSeen;  // remote core acknowledged entering reset
    logic leaveSeen;  // remote core acknowledged leaving reset
  } rcr_strobe_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } rcr_state_e;

  localparam int STAT_W = 2;
  localparam int STAT_ENTER = 0;
  localparam int STAT_LEAVE = 1;

endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int BOOT_W = 2,
  localparam int CFG_W = BOOT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              remoteAck,
  input  logic              remoteMask,
  output logic              rstActive,
  output logic [BOOT_W-1:0] cfgBoot,
  output rcr_strobe_t       strobe
);

  localparam int REQ_BIT  = 0;
  localparam int HOLD_BIT = 1;
  localparam int BOOT_LSB = 2;

  logic reqQ, holdQ;
  logic [BOOT_W-1:0] bootQ;
  rcr_state_e stateQ, stateD;
  logic ackQ, downQ;

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      holdQ <= 1'b0;
      bootQ <= '0;
    end else if (cfgWrEn) begin
      reqQ  <= cfgWrData[REQ_BIT];
      holdQ <= cfgWrData[HOLD_BIT];
      bootQ <= cfgWrData[BOOT_LSB +: BOOT_W];
    end
  end

  assign cfgBoot = bootQ;

  // reset sequencing
  always_comb begin
    stateD = stateQ;
    strobe.rstRise = 1'b0;
    strobe.rstFall = 1'b0;
    unique case (stateQ)
      ST_RUN: begin
        if (reqQ && !remoteMask) begin
          stateD = ST_HELD;
          strobe.rstRise = 1'b1;
        end
      end
      ST_HELD: begin
        if (!reqQ && !holdQ) begin
          stateD = ST_RUN;
          strobe.rstFall = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign rstActive = (stateQ == ST_HELD);

  // acknowledge tracking
  assign strobe.enterSeen = remoteAck && !ackQ && rstActive;
  assign strobe.leaveSeen = !remoteAck && ackQ && downQ && !rstActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ  <= 1'b0;
      downQ <= 1'b0;
    end else begin
      ackQ <= remoteAck;
      if (strobe.enterSeen)      downQ <= 1'b1;
      else if (strobe.leaveSeen) downQ <= 1'b0;
    end
  end

  a_r3_req_starts_reset: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ && !remoteMask && !rstActive) |=> rstActive);

  a_r4_hold_keeps_reset: assert property (@(posedge clk) disable iff (!rstN)
    (rstActive && holdQ) |=> rstActive);

  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (rstActive && !reqQ && !holdQ) |=> !rstActive);

  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (!rstActive && remoteMask) |=> !rstActive);

endmodule

// File: rtl/rcr_data.sv
module rcr_data
  import rcr_pkg::*;
#(
  parameter int BOOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcr_strobe_t       strobe,
  input  logic              rstActive,
  input  logic [BOOT_W-1:0] cfgBoot,
  input  logic              statClrEn,
  input  logic [STAT_W-1:0] statClrData,
  output logic [STAT_W-1:0] statPend,
  output logic [BOOT_W-1:0] bootMode
);

  logic [STAT_W-1:0] setVec;
  assign setVec[STAT_ENTER] = strobe.enterSeen;
  assign setVec[STAT_LEAVE] = strobe.leaveSeen;

  // sticky flags, set beats clear
  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            statPend[i] <= 1'b0;
      else if (setVec[i])                   statPend[i] <= 1'b1;
      else if (statClrEn && statClrData[i]) statPend[i] <= 1'b0;
    end
  end

  // boot mode latched at release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bootMode <= '0;
    else if (strobe.rstFall) bootMode <= cfgBoot;
  end

  a_r6_boot_stable_held: assert property (@(posedge clk) disable iff (!rstN)
    (rstActive && $past(rstActive)) |-> $stable(bootMode));

  a_r7_enter_needs_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statPend[STAT_ENTER]) |-> $past(rstActive));

  a_r8_leave_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statPend[STAT_LEAVE]) |-> !$past(rstActive));

  a_r9_clear_enter: assert property (@(posedge clk) disable iff (!rstN)
    (statClrEn && statClrData[STAT_ENTER] && !strobe.enterSeen) |=> !statPend[STAT_ENTER]);

endmodule

// File: rtl/remote_reset_ctrl.sv
module remote_reset_ctrl
  import rcr_pkg::*;
#(
  parameter int BOOT_W = 2,
  localparam int CFG_W = BOOT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              statClrEn,
  input  logic [1:0]        statClrData,
  input  logic              remoteAck,
  input  logic              remoteMask,
  output logic              remoteRst,
  output logic [BOOT_W-1:0] bootMode,
  output logic              assertPend,
  output logic              deassertPend
);

  rcr_strobe_t       strobe;
  logic              rstActive;
  logic [BOOT_W-1:0] cfgBoot;
  logic [STAT_W-1:0] statPend;

  rcr_ctrl #(.BOOT_W(BOOT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .remoteAck  (remoteAck),
    .remoteMask (remoteMask),
    .rstActive  (rstActive),
    .cfgBoot    (cfgBoot),
    .strobe     (strobe)
  );

  rcr_data #(.BOOT_W(BOOT_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rstActive   (rstActive),
    .cfgBoot     (cfgBoot),
    .statClrEn   (statClrEn),
    .statClrData (statClrData),
    .statPend    (statPend),
    .bootMode    (bootMode)
  );

  assign remoteRst    = rstActive;
  assign assertPend   = statPend[STAT_ENTER];
  assign deassertPend = statPend[STAT_LEAVE];

endmodule

// File: tb/remote_reset_ctrl_test.sv
module remote_reset_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic statClrEn = 1'b0;
  logic [1:0] statClrData = '0;
  logic remoteAck = 1'b0;
  logic remoteMask = 1'b0;
  logic remoteRst;
  logic [1:0] bootMode;
  logic assertPend, deassertPend;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  remote_reset_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .statClrEn(statClrEn), .statClrData(statClrData),
    .remoteAck(remoteAck), .remoteMask(remoteMask),
    .remoteRst(remoteRst), .bootMode(bootMode),
    .assertPend(assertPend), .deassertPend(deassertPend)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFails++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // request bit0, hold bit1, boot bits 3:2
  task automatic writeCfg(input logic req, input logic hold, input logic [1:0] boot);
    cfgWrEn = 1'b1;
    cfgWrData = {boot, hold, req};
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic clearStat(input logic [1:0] bits);
    statClrEn = 1'b1;
    statClrData = bits;
    step();
    statClrEn = 1'b0;
    statClrData = '0;
  endtask

  task automatic testResetState();
    chk("R1 remoteRst", remoteRst, 0);
    chk("R1 bootMode", bootMode, 0);
    chk("R1 assertPend", assertPend, 0);
    chk("R1 deassertPend", deassertPend, 0);
  endtask

  task automatic testBasicCycle();
    clearStat(2'b11);
    writeCfg(1'b1, 1'b0, 2'd2);
    chk("R2 no reset before request seen", remoteRst, 0);
    step();
    chk("R3 reset after request", remoteRst, 1);
    chk("R6 boot not yet applied", bootMode, 0);
    remoteAck = 1'b1;
    step();
    chk("R7 assert pending set", assertPend, 1);
    chk("R8 no deassert while held", deassertPend, 0);
    writeCfg(1'b0, 1'b0, 2'd2);
    step();
    chk("R5 release", remoteRst, 0);
    chk("R6 boot applied at release", bootMode, 2);
    remoteAck = 1'b0;
    step();
    chk("R8 deassert pending set", deassertPend, 1);
    clearStat(2'b10);
    chk("R9 clear bit1 only", deassertPend, 0);
    chk("R9 bit0 untouched", assertPend, 1);
    clearStat(2'b01);
    chk("R9 clear bit0", assertPend, 0);
  endtask

  task automatic testHold();
    writeCfg(1'b1, 1'b1, 2'd1);
    step();
    chk("R3 reset with hold", remoteRst, 1);
    // set wins over clear in the same cycle
    remoteAck = 1'b1;
    statClrEn = 1'b1;
    statClrData = 2'b01;
    step();
    statClrEn = 1'b0;
    statClrData = '0;
    chk("R9 set beats clear", assertPend, 1);
    writeCfg(1'b0, 1'b1, 2'd3);
    step(3);
    chk("R4 hold keeps reset", remoteRst, 1);
    chk("R6 boot unchanged while held", bootMode, 2);
    writeCfg(1'b0, 1'b0, 2'd3);
    step();
    chk("R5 release after hold drop", remoteRst, 0);
    chk("R6 new boot in same write", bootMode, 3);
    remoteAck = 1'b0;
    step();
    chk("R8 deassert after hold", deassertPend, 1);
    clearStat(2'b11);
  endtask

  task automatic testMask();
    remoteMask = 1'b1;
    writeCfg(1'b1, 1'b0, 2'd0);
    step(3);
    chk("R10 masked request ignored", remoteRst, 0);
    remoteAck = 1'b1;
    step();
    chk("R10 assert pending stays clear", assertPend, 0);
    remoteAck = 1'b0;
    step();
    chk("R8 no deassert without entry", deassertPend, 0);
    remoteMask = 1'b0;
    step();
    chk("R10 reset after unmask", remoteRst, 1);
    writeCfg(1'b0, 1'b0, 2'd0);
    step();
    chk("R5 release after unmask", remoteRst, 0);
    chk("R6 boot zero applied", bootMode, 0);
    chk("R8 still no deassert", deassertPend, 0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    testResetState();
    testBasicCycle();
    testHold();
    testMask();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule